// File: doc/BRIEF.md
# No-Turnaround Pipelined SRAM Core

This block is a synthesizable behavioural model of a pipelined synchronous SRAM whose data bus never needs an idle cycle when traffic switches between reads and writes. Each enabled clock edge can accept a new command. A command is a read, a write, a deselect, or the next step of a running burst. The data word is 36 bits wide. It is split into four 9-bit lanes (8 data bits plus 1 parity bit), and each lane has its own active-low write enable.

Write data follows its address by two enabled edges. A small write registry holds the addresses and data of writes that have not yet reached the array. It compares them with every read, so a read always returns the newest contents, lane by lane. Read data is registered and appears two enabled edges after the read address is taken.

The read side is a stream that carries a valid flag but has no ready input. No back-pressure exists: the consumer must accept a word in every cycle where `rvalid` is high. The only way to stall is to hold `clk_en_n` high, which freezes the whole pipeline, including the output register.

Top module: `nt_sram_core`

## Requirements
- R1: While reset is low and directly after it, `rvalid` and `rdrive` are low, `rdata` is all zeros, and no command is pending.
- R2: A new command is taken only on an enabled edge with `adv_ld` low. The block is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. When selected, `wr_n`=1 gives a read and `wr_n`=0 gives a write. Any other enable combination gives a deselect.
- R3: A read issued on enabled edge e drives `rvalid` high after enabled edge e+2, with the addressed word on the data output.
- R4: Write data on `wdata` is sampled at the second enabled edge after its address. Lane l occupies bits [9l+8:9l] and is written only when `lane_we_n[l]`=0 in the address cycle. Disabled lanes keep their old contents.
- R5: A read returns the newest data for each lane, including writes to the same address issued one or two cycles before it. When two pending writes hit the same lane, the younger write wins.
- R6: With `adv_ld` high, the previous command kind continues at the next burst address, and only the low 2 address bits change. Step k uses (start+k) mod 4 when `burst_linear`=1 and start XOR k when `burst_linear`=0. Continuing after a deselect stays a deselect.
- R7: An edge with `clk_en_n` high has no effect. Outputs hold, `wdata` is not sampled, the burst does not advance and the array is not written.
- R8: A deselect or write command drives `rvalid` low two enabled edges later. Writes already in the pipeline still complete.
- R9: `oe_n` only gates the output. `rdrive` = `rvalid` AND NOT `oe_n`, and `rdata` is zero whenever `rdrive` is low. `oe_n` has no effect on pipeline state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high suspends the edge |
| sel1_n | input | 1 | Chip enable, active low |
| sel2 | input | 1 | Chip enable, active high |
| sel3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | Low: load a new command; high: advance the burst |
| wr_n | input | 1 | Low: write, high: read |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| burst_linear | input | 1 | 1: linear burst order, 0: interleaved |
| wdata | input | 36 | Write data, two enabled edges after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Read data, zero when not driven |
| rvalid | output | 1 | Read data valid |
| rdrive | output | 1 | Output drivers active |

## Verification
The hard case is one where a single output edge merges both write-registry sources with the array word. The write that the array has just committed and the younger write whose data is still waiting for commit can both target the address being read. The bench provokes this by issuing random reads and partial-lane writes to a pool of only four addresses, with no idle cycles. This makes it common for a write at distance two, a write at distance one and a read to collide with overlapping lanes. A second collision comes from junk on `wdata` and a burst advance that fall on a suspended edge. A behavioural reference model applies each write's data in the cycle the write is due. On every clock it compares `rvalid`, `rdrive` and `rdata` against that model.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/nt_burst_seq.sv
module nt_burst_seq
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              load,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  input  op_e               op_in,
  output logic [ADDR_W-1:0] addr_out,
  output op_e               op_out
);
  logic [ADDR_W-1:0]  base_q, base_nx;
  logic [BURST_W-1:0] step_q, step_nx, low_bits;
  op_e                op_q;

  always_comb begin
    base_nx  = load ? addr_in : base_q;
    step_nx  = load ? '0 : step_q + BURST_W'(1);
    op_out   = load ? op_in : op_q;
    low_bits = linear ? (base_nx[BURST_W-1:0] + step_nx)
                      : (base_nx[BURST_W-1:0] ^ step_nx);
    addr_out = {base_nx[ADDR_W-1:BURST_W], low_bits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      op_q   <= OP_IDLE;
    end else if (ce) begin
      base_q <= base_nx;
      step_q <= step_nx;
      op_q   <= op_out;
    end
  end
endmodule

// File: rtl/nt_sram_array.sv
module nt_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      ce,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES-1:0]          wbe,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] rd_lane;

    always_ff @(posedge clk) begin
      if (ce) begin
        if (we && wbe[l]) bank[waddr] <= wdata[l*LANE_W +: LANE_W];
        rd_lane <= bank[raddr];
      end
    end

    assign rdata[l*LANE_W +: LANE_W] = rd_lane;
  end
endmodule

// File: rtl/nt_write_registry.sv
module nt_write_registry
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  op_e                     s1_op,
  input  logic [ADDR_W-1:0]       s1_addr,
  input  logic [LANES-1:0]        s1_be,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES*LANE_W-1:0] rd_raw,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_waddr,
  output logic [LANES-1:0]        mem_wbe,
  output logic [LANES*LANE_W-1:0] mem_wdata,
  output logic                    s2_read,
  output logic [LANES*LANE_W-1:0] rd_merged
);
  localparam int WORD_W = LANES * LANE_W;

  op_e               s2_op, s3_op;
  logic [ADDR_W-1:0] s2_addr, s3_addr, done_addr;
  logic [LANES-1:0]  s2_be, s3_be, done_be;
  logic [WORD_W-1:0] din_q, done_data;
  logic              done_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op     <= OP_IDLE;
      s3_op     <= OP_IDLE;
      s2_addr   <= '0;
      s3_addr   <= '0;
      s2_be     <= '0;
      s3_be     <= '0;
      din_q     <= '0;
      done_ok   <= 1'b0;
      done_addr <= '0;
      done_be   <= '0;
      done_data <= '0;
    end else if (ce) begin
      s2_op     <= s1_op;
      s2_addr   <= s1_addr;
      s2_be     <= s1_be;
      s3_op     <= s2_op;
      s3_addr   <= s2_addr;
      s3_be     <= s2_be;
      din_q     <= wdata;
      done_ok   <= (s3_op == OP_WRITE);
      done_addr <= s3_addr;
      done_be   <= s3_be;
      done_data <= din_q;
    end
  end

  assign mem_we    = ce && (s3_op == OP_WRITE);
  assign mem_waddr = s3_addr;
  assign mem_wbe   = s3_be;
  assign mem_wdata = din_q;
  assign s2_read   = (s2_op == OP_READ);

  logic hit_young, hit_old;
  assign hit_young = (s3_op == OP_WRITE) && (s3_addr == s2_addr);
  assign hit_old   = done_ok && (done_addr == s2_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    always_comb begin
      if (hit_young && s3_be[l])
        rd_merged[l*LANE_W +: LANE_W] = din_q[l*LANE_W +: LANE_W];
      else if (hit_old && done_be[l])
        rd_merged[l*LANE_W +: LANE_W] = done_data[l*LANE_W +: LANE_W];
      else
        rd_merged[l*LANE_W +: LANE_W] = rd_raw[l*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/nt_sram_core.sv
module nt_sram_core
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    adv_ld,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burst_linear,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid,
  output logic                    rdrive
);
  localparam int WORD_W = LANES * LANE_W;

  logic ce, chosen;
  op_e  new_op, cmd_op, s1_op;
  logic [ADDR_W-1:0] cmd_addr, s1_addr;
  logic [LANES-1:0]  s1_be;

  assign ce     = !clk_en_n;
  assign chosen = !sel1_n && sel2 && !sel3_n;

  always_comb begin
    if (!chosen)   new_op = OP_IDLE;
    else if (wr_n) new_op = OP_READ;
    else           new_op = OP_WRITE;
  end

  nt_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) burst_i (
    .clk(clk), .rst_n(rst_n), .ce(ce), .load(!adv_ld), .linear(burst_linear),
    .addr_in(addr), .op_in(new_op), .addr_out(cmd_addr), .op_out(cmd_op)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
    end else if (ce) begin
      s1_op   <= cmd_op;
      s1_addr <= cmd_addr;
      s1_be   <= ~lane_we_n;
    end
  end

  logic              mem_we, s2_read;
  logic [ADDR_W-1:0] mem_waddr;
  logic [LANES-1:0]  mem_wbe;
  logic [WORD_W-1:0] mem_wdata, rd_raw, rd_merged;

  nt_write_registry #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) reg_i (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be),
    .wdata(wdata), .rd_raw(rd_raw),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wbe(mem_wbe), .mem_wdata(mem_wdata),
    .s2_read(s2_read), .rd_merged(rd_merged)
  );

  nt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk(clk), .ce(ce), .we(mem_we), .waddr(mem_waddr), .wbe(mem_wbe),
    .wdata(mem_wdata), .raddr(s1_addr), .rdata(rd_raw)
  );

  logic              rvalid_q;
  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (ce) begin
      rvalid_q <= s2_read;
      if (s2_read) rdata_q <= rd_merged;
    end
  end

  assign rvalid = rvalid_q;
  assign rdrive = rvalid_q && !oe_n;
  assign rdata  = rdrive ? rdata_q : '0;
endmodule

// File: rtl/nt_sram_core_chk.sv
module nt_sram_core_chk #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2,
  parameter int WORD_W  = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              adv_ld,
  input logic              rvalid,
  input logic              rdrive,
  input logic              s2_read,
  input logic [WORD_W-1:0] rdata_q,
  input logic [ADDR_W-1:0] s1_addr
);
  // R3: a read two stages deep yields valid data after the next enabled edge
  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s2_read) |=> rvalid);

  // R8: a non-read two stages deep clears the valid flag
  a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !s2_read) |=> !rvalid);

  // R7: a suspended edge changes nothing visible
  a_r7_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(rvalid) && $stable(rdata_q) && $stable(s1_addr)));

  // R6: a burst advance keeps the upper address bits
  a_r6_burst_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld) |=>
      (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])));

  // R9: drivers stay off without valid data
  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> !rdrive);
endmodule

bind nt_sram_core nt_sram_core_chk #(
  .ADDR_W(ADDR_W), .BURST_W(BURST_W), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
  .rvalid(rvalid), .rdrive(rdrive), .s2_read(s2_read),
  .rdata_q(rdata_q), .s1_addr(s1_addr)
);

// File: tb/nt_sram_core_tb_top.sv
module nt_sram_core_tb_top;
  localparam int AW = 8;
  localparam int DW = 36;
  localparam logic [2:0] EN_ON = 3'b010;

  logic clk = 1'b0;
  logic rst_n;
  logic clk_en_n = 1'b0, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic adv_ld = 1'b0, wr_n = 1'b1, burst_linear = 1'b1, oe_n = 1'b0;
  logic [3:0]    lane_we_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid, rdrive;

  always #4 clk = ~clk;

  nt_sram_core dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .adv_ld(adv_ld), .wr_n(wr_n), .lane_we_n(lane_we_n),
    .addr(addr), .burst_linear(burst_linear), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rvalid(rvalid), .rdrive(rdrive)
  );

  int n_chk = 0, n_fail = 0;
  bit run_chk = 0, finished = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // reference model: op 0 idle, 1 read, 2 write
  typedef struct { int op; int a; logic [3:0] be; } cmd_t;
  cmd_t q[$];
  logic [DW-1:0] mmem [256];
  int  m_op, m_base, m_cnt;
  bit  exp_valid;
  logic [DW-1:0] exp_data;

  always @(posedge clk) begin
    cmd_t c;
    cmd_t o;
    if (!rst_n) begin
      q.delete();
      m_op = 0; m_base = 0; m_cnt = 0; exp_valid = 0;
    end else if (!clk_en_n) begin
      if (!adv_ld) begin
        m_base = int'(addr);
        m_cnt  = 0;
        m_op   = (!sel1_n && sel2 && !sel3_n) ? (wr_n ? 1 : 2) : 0;
      end else m_cnt = (m_cnt + 1) % 4;
      c.op = m_op;
      c.a  = (m_base & ~3) | (burst_linear ? ((m_base + m_cnt) % 4) : ((m_base % 4) ^ m_cnt));
      c.be = ~lane_we_n;
      q.push_back(c);
      exp_valid = 0;
      if (q.size() >= 3) begin
        o = q[q.size()-3];
        if (o.op == 2)
          for (int l = 0; l < 4; l++)
            if (o.be[l]) mmem[o.a][l*9 +: 9] = wdata[l*9 +: 9];
        if (o.op == 1) begin
          exp_valid = 1;
          exp_data  = mmem[o.a];
        end
      end
      if (q.size() > 3) void'(q.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      chk(rvalid === exp_valid, cur_req, {35'd0, rvalid}, {35'd0, exp_valid});
      chk(rdrive === (exp_valid && !oe_n), "R9", {35'd0, rdrive}, {35'd0, exp_valid && !oe_n});
      if (exp_valid && !oe_n) chk(rdata === exp_data, cur_req, rdata, exp_data);
      else chk(rdata === '0, "R9", rdata, '0);
    end
  end

  logic [DW-1:0] dpipe0 = '0, dpipe1 = '0;

  task automatic tick(bit ce, bit adv, logic [2:0] en, bit wr, logic [AW-1:0] a,
                      logic [3:0] wen_n, logic [DW-1:0] d, bit oe);
    @(negedge clk); #1;
    clk_en_n = !ce; adv_ld = adv; {sel1_n, sel2, sel3_n} = en; wr_n = !wr;
    addr = a; lane_we_n = wen_n; oe_n = !oe;
    if (ce) begin
      wdata  = dpipe1;
      dpipe1 = dpipe0;
      dpipe0 = d;
    end else wdata = {4'($urandom()), 32'($urandom())};
  endtask

  task automatic rand_run(int n, string req, int p_off, int p_adv, int p_desel,
                          bit rnd_oe, int amask, bit rnd_lin);
    cur_req = req;
    repeat (n) begin
      bit ce, adv, wr, oe;
      logic [2:0] en;
      ce  = ($urandom() % 100) >= p_off;
      adv = ($urandom() % 100) < p_adv;
      wr  = $urandom() % 2;
      oe  = rnd_oe ? ($urandom() % 4 != 0) : 1'b1;
      en  = (($urandom() % 100) < p_desel) ? (EN_ON ^ (3'b001 << ($urandom() % 3))) : EN_ON;
      if (rnd_lin && !adv) burst_linear = $urandom() % 2;
      tick(ce, adv, en, wr, AW'($urandom() & amask), 4'($urandom()),
           {4'($urandom()), 32'($urandom())}, oe);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(rvalid === 1'b0, "R1", {35'd0, rvalid}, '0);
    chk(rdrive === 1'b0, "R1", {35'd0, rdrive}, '0);
    chk(rdata === '0, "R1", rdata, '0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rvalid === 1'b0, "R1", {35'd0, rvalid}, '0);
    run_chk = 1;

    // R4: fill the array with full-lane single writes
    cur_req = "R4";
    for (int i = 0; i < 256; i++)
      tick(1, 0, EN_ON, 1, AW'(i), 4'h0, {4'(i), 32'(i * 32'h9E3779B1)}, 1);
    cur_req = "R8";
    repeat (3) tick(1, 0, 3'b110, 0, '0, 4'hF, '0, 1);
    // R3: back-to-back reads
    cur_req = "R3";
    for (int i = 0; i < 64; i++) tick(1, 0, EN_ON, 0, AW'(i * 3), 4'hF, '0, 1);
    // R4: partial-lane writes then reads of the same word
    cur_req = "R4";
    tick(1, 0, EN_ON, 1, 8'd10, 4'b1010, 36'hFFFFFFFFF, 1);
    tick(1, 0, EN_ON, 0, 8'd10, 4'hF, '0, 1);
    tick(1, 0, 3'b110, 0, 8'd0, 4'hF, '0, 1);
    tick(1, 0, EN_ON, 0, 8'd10, 4'hF, '0, 1);
    rand_run(400, "R5", 0, 0, 0, 0, 3, 0);
    rand_run(300, "R6", 0, 60, 10, 0, 7, 1);
    rand_run(300, "R7", 30, 30, 10, 1, 7, 1);
    rand_run(200, "R8", 0, 20, 40, 0, 3, 0);
    rand_run(200, "R9", 0, 20, 10, 1, 3, 0);
    rand_run(300, "R2", 10, 30, 30, 1, 255, 1);
    cur_req = "R8";
    repeat (4) tick(1, 0, 3'b011, 0, '0, 4'hF, '0, 1);
    @(negedge clk);
    chk(rvalid === 1'b0, "R8", {35'd0, rvalid}, '0);
    finish_run();
  end
endmodule